// File: doc/BRIEF.md
# Real-Time-Clock Prescaler with BCD Seconds Counter

This block is the timebase of a real-time clock. A 128 Hz enable (`tick_i`) drives a seven-stage binary divider, and each stage toggles at half the rate of the one below it. The divider's state can be read back through an 8-bit register. When the divider rolls over from all-ones to zero it produces a 1 Hz carry. That carry advances a two-digit BCD seconds register. When the seconds wrap from 59 to 00, the block emits a one-clock minute carry for the next stage of the clock.

Software drives the block through a small synchronous register port. The port has three registers:
- the divider readout, which is read-only;
- the seconds register, which can be read and written;
- a control register holding a run bit, plus two self-clearing strobes that zero the divider.

The divider has no system reset, so its phase survives a reset of the chip. The intended use is to stop the count, load the seconds, zero the divider, and then restart.

Top module: `rtc_secbase`

## Requirements
- R1: A read of address 0 returns the divider. Bit 7 is always 0. Bits 0 to 6 hold a binary count of the accepted ticks, so bit k toggles every 2^k ticks: bit 0 is the 64 Hz stage and bit 6 is the 1 Hz stage.
- R2: A write to address 2 with data bit 1 (clear strobe) or data bit 2 (adjust strobe) set zeroes the divider on that clock edge. The clear takes priority over a tick in the same cycle.
- R3: `rst_ni` does not change the divider. Its value before reset can still be read after reset.
- R4: The divider advances on `tick_i` only while the run bit (bit 0 of address 2) is 1. With the run bit at 0, ticks leave both the divider and the seconds unchanged.
- R5: The seconds register increments once for every 128 accepted ticks, on the tick that takes the divider from 0x7F to 0x00.
- R6: Seconds count in BCD. 0x09 steps to 0x10, 0x23 steps to 0x24, and 0x59 steps to 0x00.
- R7: On the step from 0x59 to 0x00, `min_carry_o` is 1 for exactly one clock, in the cycle where seconds first hold 0x00.
- R8: A write to address 1 stores the data byte into seconds exactly as written, and takes priority over a count in the same cycle.
- R9: `rdata_o` is registered. It shows the register at `addr_i` one clock after the address is presented. Address 2 reads the run bit in bit 0 and zeros in all other bits.
- R10: While `rst_ni` is low, the seconds, the run bit, `min_carry_o` and `rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (does not reach the divider) |
| tick_i | input | 1 | 128 Hz enable, one clock wide per tick |
| wr_i | input | 1 | Write strobe for the register at addr_i |
| addr_i | input | 2 | Register select: 0 divider, 1 seconds, 2 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one clock after addr_i |
| min_carry_o | output | 1 | One-clock pulse on the 59-to-00 wrap of the seconds |

## Verification
A write or strobe changes the divider, the seconds and the run bit at the clock edge that samples it. Read data is due one edge after the address is set up. The minute carry rises at the edge that takes the seconds to 00, and it falls at the following edge. The bench drives every input at the falling edge and samples at the next falling edge after the edge where a result is due. It keeps `tick_i` low during reads, so each readback shows settled register contents.

// File: rtl/rtc_secbase_pkg.sv
package rtc_secbase_pkg;
  typedef enum logic [1:0] {
    RA_DIV  = 2'd0,
    RA_SEC  = 2'd1,
    RA_CTRL = 2'd2
  } reg_addr_e;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_CLR = 1;
  localparam int CTRL_ADJ = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int STAGES = 7
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              clr_i,
  output logic [STAGES-1:0] cnt_o,
  output logic              carry_o
);
  logic [STAGES-1:0] cnt_q;

  // no system reset: phase survives rst_ni by design
  always_ff @(posedge clk_i) begin
    if (clr_i)     cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign carry_o = en_i && !clr_i && (&cnt_q);
endmodule

// File: rtl/rtc_bcd_digit.sv
module rtc_bcd_digit #(
  parameter int LIMIT = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [3:0] ld_val_i,
  input  logic       inc_i,
  output logic [3:0] val_o,
  output logic       wrap_o
);
  localparam logic [3:0] LIM = 4'(LIMIT);

  logic [3:0] val_q;

  assign wrap_o = inc_i && (val_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (ld_i)   val_q <= ld_val_i;
    else if (wrap_o) val_q <= '0;
    else if (inc_i)  val_q <= val_q + 4'd1;
  end

  assign val_o = val_q;
endmodule

// File: rtl/rtc_bcd_sec.sv
module rtc_bcd_sec #(
  parameter int DIGITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic [4*DIGITS-1:0] ld_val_i,
  input  logic                inc_i,
  output logic [4*DIGITS-1:0] val_o,
  output logic                wrap_o
);
  logic [DIGITS:0] inc_chain;

  assign inc_chain[0] = inc_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    // units wrap after 9, tens after 5
    localparam int LIM = (g % 2 == 0) ? 9 : 5;
    rtc_bcd_digit #(.LIMIT(LIM)) i_digit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_i    (ld_i),
      .ld_val_i(ld_val_i[4*g +: 4]),
      .inc_i   (inc_chain[g]),
      .val_o   (val_o[4*g +: 4]),
      .wrap_o  (inc_chain[g+1])
    );
  end

  assign wrap_o = inc_chain[DIGITS];
endmodule

// File: rtl/rtc_secbase.sv
module rtc_secbase
  import rtc_secbase_pkg::*;
#(
  parameter int DIV_STAGES = 7,
  parameter int SEC_DIGITS = 2,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              min_carry_o
);
  localparam int DIV_PAD = DATA_W - DIV_STAGES;
  localparam int SEC_W   = 4 * SEC_DIGITS;

  logic                  run_q;
  logic                  ctrl_wr, sec_wr, div_clr;
  logic                  div_carry, sec_wrap;
  logic [DIV_STAGES-1:0] div_q;
  logic [SEC_W-1:0]      sec_q;
  logic [DATA_W-1:0]     rd_mux, rdata_q;
  logic                  min_q;

  assign ctrl_wr = wr_i && (addr_i == RA_CTRL);
  assign sec_wr  = wr_i && (addr_i == RA_SEC);
  // strobes self-clear: they exist only in the write cycle
  assign div_clr = ctrl_wr && (wdata_i[CTRL_CLR] || wdata_i[CTRL_ADJ]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (ctrl_wr) run_q <= wdata_i[CTRL_RUN];
  end

  rtc_prescaler #(.STAGES(DIV_STAGES)) i_pre (
    .clk_i  (clk_i),
    .en_i   (tick_i && run_q),
    .clr_i  (div_clr),
    .cnt_o  (div_q),
    .carry_o(div_carry)
  );

  rtc_bcd_sec #(.DIGITS(SEC_DIGITS)) i_sec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (sec_wr),
    .ld_val_i(wdata_i[SEC_W-1:0]),
    .inc_i   (div_carry),
    .val_o   (sec_q),
    .wrap_o  (sec_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) min_q <= 1'b0;
    else         min_q <= sec_wrap && !sec_wr;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      RA_DIV:  rd_mux = {{DIV_PAD{1'b0}}, div_q};
      RA_SEC:  rd_mux = DATA_W'(sec_q);
      RA_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, run_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_mux;
  end

  assign rdata_o     = rdata_q;
  assign min_carry_o = min_q;
endmodule

// File: rtl/rtc_secbase_chk.sv
module rtc_secbase_chk
  import rtc_secbase_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       min_carry_o,
  input logic       run_i,
  input logic [6:0] div_i,
  input logic [7:0] sec_i
);
  logic clr_wr, sec_wr;
  assign clr_wr = wr_i && (addr_i == RA_CTRL) && (wdata_i[CTRL_CLR] || wdata_i[CTRL_ADJ]);
  assign sec_wr = wr_i && (addr_i == RA_SEC);

  AST_DIV_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(addr_i) == RA_DIV) |-> (rdata_o[7] == 1'b0)); // R1
  AST_STROBE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (div_i == '0)); // R2
  AST_DIV_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_wr) |=> $stable(div_i)); // R4
  AST_SEC_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_wr && !(tick_i && run_i)) |=> $stable(sec_i)); // R5
  AST_MIN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_carry_o |=> !min_carry_o); // R7
  AST_MIN_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_carry_o |-> (sec_i == 8'h00)); // R7
  AST_SEC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wr |=> (sec_i == $past(wdata_i))); // R8
endmodule

bind rtc_secbase rtc_secbase_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .min_carry_o(min_carry_o),
  .run_i      (run_q),
  .div_i      (div_q),
  .sec_i      (sec_q)
);

// File: tb/test_rtc_secbase.sv
module test_rtc_secbase;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       min_carry;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_secbase i_rtc_secbase (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .min_carry_o(min_carry)
  );

  typedef struct packed {
    logic [7:0]  sec0;
    logic [15:0] ticks;
    logic [7:0]  sec_exp;
    logic [7:0]  div_exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'd1,   8'h00, 8'h01},
    '{8'h00, 16'd127, 8'h00, 8'h7F},
    '{8'h00, 16'd128, 8'h01, 8'h00},
    '{8'h09, 16'd128, 8'h10, 8'h00},
    '{8'h58, 16'd128, 8'h59, 8'h00},
    '{8'h59, 16'd128, 8'h00, 8'h00},
    '{8'h23, 16'd200, 8'h24, 8'h48},
    '{8'h45, 16'd384, 8'h48, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R10 rdata in reset", rdata, 8'h00);
    check("R10 min_carry in reset", {7'd0, min_carry}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(2'd1, v); check("R10 seconds after reset", v, 8'h00);
    rd_reg(2'd2, v); check("R10 run bit after reset", v, 8'h00);

    // vector table: R1 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      wr_reg(2'd2, 8'h02);
      wr_reg(2'd1, VECS[k].sec0);
      wr_reg(2'd2, 8'h01);
      ticks(int'(VECS[k].ticks));
      wr_reg(2'd2, 8'h00);
      rd_reg(2'd0, v); check("R1 R5 divider", v, VECS[k].div_exp);
      rd_reg(2'd1, v); check("R5 R6 seconds", v, VECS[k].sec_exp);
    end

    // R9: strobe bits read back as 0
    wr_reg(2'd2, 8'h07);
    rd_reg(2'd2, v); check("R9 control readback", v, 8'h01);
    wr_reg(2'd2, 8'h00);

    // R2 clear strobe and R4 stopped ticks, then R3 across reset
    wr_reg(2'd2, 8'h03);
    ticks(37);
    wr_reg(2'd2, 8'h01);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ticks(5);
    rd_reg(2'd0, v); check("R3 R4 divider kept over reset", v, 8'h25);
    rd_reg(2'd2, v); check("R10 run bit cleared", v, 8'h00);
    rd_reg(2'd1, v); check("R4 seconds unchanged stopped", v, 8'h00);

    // R2 adjust strobe
    wr_reg(2'd2, 8'h04);
    rd_reg(2'd0, v); check("R2 adjust clears divider", v, 8'h00);

    // R7 minute carry timing
    wr_reg(2'd1, 8'h59);
    wr_reg(2'd2, 8'h03);
    ticks(127);
    check("R7 no carry before wrap", {7'd0, min_carry}, 8'h00);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R7 carry pulse high", {7'd0, min_carry}, 8'h01);
    @(negedge clk);
    check("R7 carry pulse one clock", {7'd0, min_carry}, 8'h00);
    wr_reg(2'd2, 8'h00);
    rd_reg(2'd1, v); check("R6 R7 seconds wrapped", v, 8'h00);

    // R8 raw store
    wr_reg(2'd1, 8'h7F);
    rd_reg(2'd1, v); check("R8 raw seconds write", v, 8'h7F);
    wr_reg(2'd1, 8'h30);
    rd_reg(2'd1, v); check("R8 seconds write", v, 8'h30);
    rd_reg(2'd0, v); check("R1 bit7 zero", {v[7], 7'd0}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule